// File: doc/BRIEF.md
# Protected Memory Blind-Verify Sequencer

This block lets an external tester confirm the contents of a read-protected on-chip program memory without the chip ever revealing an address or a stored word. The tester straps three mode pins to the verify combination while holding reset. Once reset is released, the block produces a free-running strobe. The tester answers each strobe by placing the byte it believes is stored at the next location on an 8-bit input bus.

The block keeps its own address counter, starting at zero and stepping once per strobe. Shortly before each latch point it issues a read to the internal memory. At the latch point it compares the tester's byte with the stored word. A single status pin stays high while every comparison has matched. It drops low on the first mismatch and stays low until the next reset. After the last location has been checked, the strobe keeps running but no further reads or comparisons take place. When the straps are in any other combination at reset, the block stays quiet.

Top module: `pmem_blind_verify`

## Requirements
- R1: Verify mode is entered only if, while reset is asserted, `strap_lo` is 0 and both `strap_hi0` and `strap_hi1` are 1. In any other combination the strobe stays low, `vfy_ok` stays high, no memory read is issued, and `mem_addr` holds 0.
- R2: In verify mode the first strobe rise follows the first clock edge after reset release. The strobe then repeats every 3*PHASE_CYC clock cycles and is high for PHASE_CYC cycles of each period.
- R3: `exp_byte` is captured on the clock edge that falls PERIOD = 3*PHASE_CYC cycles after a strobe rise, which is the same edge as the next rise. A mismatch captured there makes `vfy_ok` low from that edge onward.
- R4: The byte answering the first strobe is compared with memory address 0. The byte answering strobe n is compared with address n-1, so successive reads use consecutive addresses.
- R5: Each memory read is a one-cycle `mem_rd_en` pulse issued one cycle before the latch point, with `mem_addr` set to the current pointer. `mem_rdata` is taken one cycle after the request.
- R6: `vfy_ok` is 1 while no mismatch has occurred and 0 after any mismatch. It stays 0 until reset.
- R7: After DEPTH comparisons the pointer stops, `mem_rd_en` stays low, and later bytes are ignored: `vfy_ok` is unchanged even by wrong bytes. The strobe keeps running.
- R8: Strap changes after reset release have no effect. A verify run continues, and an idle block stays idle.
- R9: While reset is asserted the strobe is low, `vfy_ok` is high, and `mem_rd_en` is low. Reset also clears a recorded mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are sampled while it is high |
| strap_lo | input | 1 | Mode strap that must be low for verify mode |
| strap_hi0 | input | 1 | Mode strap that must be high for verify mode |
| strap_hi1 | input | 1 | Mode strap that must be high for verify mode |
| exp_byte | input | DATA_W | Expected byte supplied by the tester |
| vfy_strobe | output | 1 | Periodic strobe to the tester |
| vfy_ok | output | 1 | High = all comparisons matched, low = mismatch seen |
| mem_rd_en | output | 1 | Internal memory read request |
| mem_addr | output | ADDR_W | Internal memory read address |
| mem_rdata | input | DATA_W | Internal memory read data, valid one cycle after request |

## Verification
The hardest case to reach from the ports is a mismatch at the final address, followed by wrong bytes after the pointer has stopped. That case must show exactly one fall of `vfy_ok`, at the right strobe, and nothing afterwards. The stimulus reaches it by modelling the tester: each strobe rise is answered with the correct word, except at a chosen index, and with deliberately wrong words once DEPTH bytes have been sent. The bench records the strobe number at which `vfy_ok` falls and compares it with the index plus two. Strap flips in the middle of a run, and resets in the middle of a failing run, cover mode latching and clearing of the sticky error.

// File: rtl/pbv_pkg.sv
package pbv_pkg;

    // Pointer walk progress
    typedef enum logic [0:0] {
        WALK_ACTIVE = 1'b0,
        WALK_DONE   = 1'b1
    } walk_state_e;

    // Decode of the mode straps into the verify request
    function automatic logic verify_strap(input logic lo, input logic hi0, input logic hi1);
        return (!lo) && hi0 && hi1;
    endfunction

endpackage

// File: rtl/pbv_strobe_gen.sv
module pbv_strobe_gen #(
    parameter int PHASE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic strobe,
    output logic rd_slot,
    output logic latch_slot
);
    localparam int PERIOD = 3 * PHASE_CYC;
    localparam int CNT_W  = $clog2(PERIOD);

    typedef struct packed {
        logic             started;
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (run) begin
            if (!gen_q.started) begin
                gen_d.started = 1'b1;
                gen_d.cnt     = '0;
            end else if (gen_q.cnt == CNT_W'(PERIOD - 1)) begin
                gen_d.cnt = '0;
            end else begin
                gen_d.cnt = gen_q.cnt + 1'b1;
            end
            gen_d.strobe = (gen_d.cnt < CNT_W'(PHASE_CYC));
        end else begin
            gen_d.started = 1'b0;
            gen_d.cnt     = '0;
            gen_d.strobe  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign strobe     = gen_q.strobe;
    // read slot sits one cycle ahead of the latch slot
    assign rd_slot    = gen_q.started && (gen_q.cnt == CNT_W'(PERIOD - 2));
    assign latch_slot = gen_q.started && (gen_q.cnt == CNT_W'(PERIOD - 1));
endmodule

// File: rtl/pbv_addr_walk.sv
module pbv_addr_walk
    import pbv_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_slot,
    input  logic              latch_slot,
    output logic              rd_en,
    output logic              cmp_en,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] ptr;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  live;

    assign live = (walk_q.state == WALK_ACTIVE);

    always_comb begin
        walk_d = walk_q;
        if (live && latch_slot) begin
            if (walk_q.ptr == LAST) begin
                walk_d.state = WALK_DONE;
            end else begin
                walk_d.ptr = walk_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_q.state <= WALK_ACTIVE;
            walk_q.ptr   <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign rd_en  = live && rd_slot;
    assign cmp_en = live && latch_slot;
    assign ptr    = walk_q.ptr;
endmodule

// File: rtl/pbv_result.sv
module pbv_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] exp_byte,
    input  logic [DATA_W-1:0] rd_word,
    output logic              ok
);
    typedef struct packed {
        logic err;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        // sticky: once set, only reset clears it
        if (cmp_en && (exp_byte != rd_word)) begin
            res_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign ok = !res_q.err;
endmodule

// File: rtl/pmem_blind_verify.sv
module pmem_blind_verify
    import pbv_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PHASE_CYC = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_lo,
    input  logic              strap_hi0,
    input  logic              strap_hi1,
    input  logic [DATA_W-1:0] exp_byte,
    output logic              vfy_strobe,
    output logic              vfy_ok,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic mode_d, mode_q;
    logic rd_slot, latch_slot, cmp_en;
    logic strobe_raw, ok_raw, rd_raw;
    logic [ADDR_W-1:0] ptr;

    // Straps are only looked at while reset is held
    always_comb begin
        mode_d = mode_q;
        if (rst) begin
            mode_d = verify_strap(strap_lo, strap_hi0, strap_hi1);
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    pbv_strobe_gen #(
        .PHASE_CYC (PHASE_CYC)
    ) u_gen (
        .clk        (clk),
        .rst        (rst),
        .run        (mode_q),
        .strobe     (strobe_raw),
        .rd_slot    (rd_slot),
        .latch_slot (latch_slot)
    );

    pbv_addr_walk #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .rd_slot    (rd_slot),
        .latch_slot (latch_slot),
        .rd_en      (rd_raw),
        .cmp_en     (cmp_en),
        .ptr        (ptr)
    );

    pbv_result #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk      (clk),
        .rst      (rst),
        .cmp_en   (cmp_en),
        .exp_byte (exp_byte),
        .rd_word  (mem_rdata),
        .ok       (ok_raw)
    );

    assign vfy_strobe = strobe_raw;
    assign vfy_ok     = ok_raw;
    assign mem_rd_en  = rd_raw && !rst;
    assign mem_addr   = ptr;
endmodule

// File: rtl/pbv_checker.sv
module pbv_checker #(
    parameter int DEPTH     = 16,
    parameter int PHASE_CYC = 2,
    parameter int ADDR_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              mode,
    input logic              vfy_strobe,
    input logic              vfy_ok,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int PERIOD = 3 * PHASE_CYC;
    localparam int GAP_W  = $clog2(PERIOD + 2) + 1;

    logic             strobe_prev, rise_seen, rd_seen;
    logic [GAP_W-1:0] gap;
    logic [ADDR_W-1:0] last_addr;
    logic             rise;

    assign rise = vfy_strobe && !strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b0;
            rise_seen   <= 1'b0;
            rd_seen     <= 1'b0;
            gap         <= '0;
            last_addr   <= '0;
        end else begin
            strobe_prev <= vfy_strobe;
            if (rise) begin
                rise_seen <= 1'b1;
                gap       <= GAP_W'(1);
            end else if (gap < GAP_W'(PERIOD + 1)) begin
                gap <= gap + 1'b1;
            end
            if (mem_rd_en) begin
                rd_seen   <= 1'b1;
                last_addr <= mem_addr;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (!vfy_strobe && vfy_ok && !mem_rd_en && mem_addr == '0));

    assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
        (rise && rise_seen) |-> (gap == GAP_W'(PERIOD)));

    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (rst)
        (!vfy_strobe && strobe_prev && rise_seen) |-> (gap == GAP_W'(PHASE_CYC)));

    assert_single_read_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    assert_first_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !rd_seen) |-> (mem_addr == '0));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && rd_seen) |-> (mem_addr == ADDR_W'(last_addr + 1'b1)));

    assert_sticky_fail_R6: assert property (@(posedge clk) disable iff (rst)
        !vfy_ok |=> !vfy_ok);

    assert_addr_bound_R7: assert property (@(posedge clk) disable iff (rst)
        mem_addr <= ADDR_W'(DEPTH - 1));
endmodule

bind pmem_blind_verify pbv_checker #(
    .DEPTH     (DEPTH),
    .PHASE_CYC (PHASE_CYC),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_q),
    .vfy_strobe (vfy_strobe),
    .vfy_ok     (vfy_ok),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr)
);

// File: tb/pmem_blind_verify_bench.sv
`timescale 1ns/1ps
module pmem_blind_verify_bench;
    localparam int DEPTH     = 16;
    localparam int PHASE_CYC = 2;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = $clog2(DEPTH);
    localparam int PERIOD    = 3 * PHASE_CYC;
    localparam int NONE      = 31;
    localparam int RUN_CYC   = (DEPTH + 3) * PERIOD + 2;
    localparam int EXP_RISES = (RUN_CYC - 2) / PERIOD + 1;
    localparam int NVEC      = 9;
    // {flip, strap_lo, strap_hi0, strap_hi1, bad index}
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 3'b011, 5'd31}, {1'b0, 3'b011, 5'd0}, {1'b0, 3'b011, 5'd15},
        {1'b0, 3'b011, 5'd7},  {1'b0, 3'b111, 5'd31}, {1'b0, 3'b001, 5'd31},
        {1'b0, 3'b010, 5'd31}, {1'b1, 3'b011, 5'd31}, {1'b1, 3'b111, 5'd31}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic s_lo = 1'b0, s_hi0 = 1'b1, s_hi1 = 1'b1;
    logic [DATA_W-1:0] exp_byte, mem_rdata;
    logic vfy_strobe, vfy_ok, mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;

    int checks = 0, fails = 0;
    int rises, gap, gap_err, width_err, rd_cnt, addr_err, fall_at, bad_idx;
    logic mon_on = 1'b0, strb_prev, st_prev;

    always #5 clk = ~clk;

    pmem_blind_verify u_pmem_blind_verify (
        .clk(clk), .rst(rst), .strap_lo(s_lo), .strap_hi0(s_hi0), .strap_hi1(s_hi1),
        .exp_byte(exp_byte), .vfy_strobe(vfy_strobe), .vfy_ok(vfy_ok),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] word_at(int a);
        return DATA_W'((a * 37 + 5) & 255);
    endfunction

    // internal memory model: registered read, address sequence recorded
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= word_at(int'(mem_addr));
            if (int'(mem_addr) != rd_cnt) addr_err++;
            rd_cnt++;
        end
    end

    // tester model: answers each strobe rise, tracks timing and status
    always @(negedge clk) begin
        if (!mon_on) begin
            exp_byte  = '0;
            strb_prev = 1'b0;
            st_prev   = 1'b1;
        end else begin
            gap++;
            if (vfy_strobe && !strb_prev) begin
                rises++;
                if (rises > 1 && gap != PERIOD) gap_err++;
                gap = 0;
                if (rises - 1 == bad_idx)   exp_byte = word_at(rises - 1) ^ 8'h5A;
                else if (rises - 1 >= DEPTH) exp_byte = word_at(rises - 1) ^ 8'hFF;
                else                         exp_byte = word_at(rises - 1);
            end
            if (!vfy_strobe && strb_prev && gap != PHASE_CYC) width_err++;
            if (st_prev && !vfy_ok && fall_at < 0) fall_at = rises;
            strb_prev = vfy_strobe;
            st_prev   = vfy_ok;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic start_reset(input logic lo, input logic h0, input logic h1, input int bad);
        mon_on = 1'b0; rst = 1'b1;
        s_lo = lo; s_hi0 = h0; s_hi1 = h1;
        rises = 0; gap = 0; gap_err = 0; width_err = 0;
        rd_cnt = 0; addr_err = 0; fall_at = -1; bad_idx = bad;
        step(3);
        chk(vfy_strobe == 1'b0, "R9", "strobe in reset", int'(vfy_strobe), 0);
        chk(vfy_ok == 1'b1, "R9", "status in reset", int'(vfy_ok), 1);
        chk(mem_rd_en == 1'b0, "R9", "read in reset", int'(mem_rd_en), 0);
        rst = 1'b0; mon_on = 1'b1;
    endtask

    task automatic run_case(input logic [8:0] v);
        bit mode;
        int bad;
        mode = !v[7] && v[6] && v[5];
        bad  = int'(v[4:0]);
        start_reset(v[7], v[6], v[5], bad);
        step(10);
        if (v[8]) begin
            if (mode) begin s_lo = 1'b1; s_hi0 = 1'b0; s_hi1 = 1'b0; end
            else      begin s_lo = 1'b0; s_hi0 = 1'b1; s_hi1 = 1'b1; end
        end
        step(RUN_CYC - 10);
        mon_on = 1'b0;
        if (mode) begin
            chk(rises == EXP_RISES, v[8] ? "R8" : "R2", "strobe rises", rises, EXP_RISES);
            chk(gap_err == 0, "R2", "period errors", gap_err, 0);
            chk(width_err == 0, "R2", "width errors", width_err, 0);
            chk(rd_cnt == DEPTH, "R5", "read count", rd_cnt, DEPTH);
            chk(addr_err == 0, "R4", "address order errors", addr_err, 0);
            if (bad == NONE) begin
                chk(vfy_ok == 1'b1, "R7", "status after ignored bytes", int'(vfy_ok), 1);
                chk(fall_at == -1, "R6", "status never fell", fall_at, -1);
            end else begin
                chk(vfy_ok == 1'b0, "R6", "sticky status", int'(vfy_ok), 0);
                chk(fall_at == bad + 2, "R3", "fall strobe", fall_at, bad + 2);
            end
        end else begin
            chk(rises == 0, v[8] ? "R8" : "R1", "idle rises", rises, 0);
            chk(rd_cnt == 0, "R1", "idle reads", rd_cnt, 0);
            chk(vfy_ok == 1'b1, "R1", "idle status", int'(vfy_ok), 1);
            chk(mem_addr == '0, "R1", "idle address", int'(mem_addr), 0);
        end
    endtask

    initial begin
        exp_byte = '0;
        mem_rdata = '0;
        for (int i = 0; i < NVEC; i++) run_case(VEC[i]);

        // reset in the middle of a failing run clears the error and restarts at 0
        start_reset(1'b0, 1'b1, 1'b1, 0);
        step(3 * PERIOD);
        chk(vfy_ok == 1'b0, "R6", "fail before mid reset", int'(vfy_ok), 0);
        start_reset(1'b0, 1'b1, 1'b1, NONE);
        step(RUN_CYC);
        mon_on = 1'b0;
        chk(vfy_ok == 1'b1, "R9", "status after re-reset run", int'(vfy_ok), 1);
        chk(addr_err == 0, "R4", "restart from address 0", addr_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule